// File: doc/BRIEF.md
# Resource-Tag World-Wide-Name Extractor

This block walks a tagged resource-descriptor image held in a byte-addressable buffer of up to 128 bytes, such as a table just copied out of a serial EEPROM. It fetches one byte at a time through a read port with fixed latency and hops from tag to tag. A tag may use the compact one-byte header or the extended header with a 16-bit length. The block enters the one extended tag that holds identity data and walks its sub-fields until it finds the sub-field that carries an 8-byte world-wide name. It reports the name, the byte offset where the name starts, a found flag and a one-cycle done pulse.

A host pulses `start` after the buffer is filled and waits for `done`. The parse is a named state machine. In `ST_IDLE` it waits for start. `ST_TAG` fetches a tag header. `ST_LEN_LO` and `ST_LEN_HI` fetch an extended length. `ST_SUB_HDR`, `ST_SUB_LO` and `ST_SUB_HI` fetch a sub-field header and its length. `ST_NAME` fetches the eight name bytes. `ST_SUB_NEXT` steps to the next sub-field. `ST_ADVANCE` steps to the next tag. `ST_FINISH` raises done.

The transitions are these. Start moves the machine from IDLE to TAG. A compact tag goes to ADVANCE, an end tag goes to FINISH and an extended tag goes to LEN_LO, then LEN_HI. The identity tag goes from LEN_HI to SUB_HDR and any other extended tag goes to ADVANCE. SUB_HDR goes to ADVANCE on the shortcut byte or when the tag body is empty, and to SUB_LO otherwise. SUB_LO goes to SUB_HI. SUB_HI goes to NAME when the sub-field code matches and to SUB_NEXT otherwise. The last NAME byte leads to SUB_NEXT. SUB_NEXT goes to SUB_HDR or ADVANCE. ADVANCE goes to TAG, or to FINISH once the offset leaves the buffer. From any fetching state, an out-of-range address leads to FINISH. FINISH returns to IDLE.

Top module: `wwn_tag_walker`

## Requirements
- R1: During and right after reset, `rd_en`, `done` and `found` are 0, and `wwn` and `wwn_off` are all zeros.
- R2: A byte with bit 7 equal to 0 is a compact tag. Its name is bits 6:3 and it spans 1 + bits 2:0 bytes. For example, 0x12 spans 3 bytes and 0x3C spans 5 bytes.
- R3: A compact tag whose name field is 0xF (for example 0x78, 0x7D or 0x7F) ends the scan, and nothing after it is examined.
- R4: A byte with bit 7 equal to 1 is an extended tag. Its name is bits 6:0, and it spans 3 bytes plus the little-endian 16-bit count held in the two following bytes. Extended tags other than name 0x0D are skipped whole.
- R5: Inside extended tag 0x0D the first sub-field header sits 3 bytes after the tag byte and is always fetched. A sub-field's code is the low 6 bits of its header byte, followed by a little-endian 16-bit length. The walk moves on by length + 3 while the sub-field offset stays below the end of the tag.
- R6: If the first body byte of tag 0x0D is 0x3B, that tag is treated as 6 bytes long and its sub-fields are not walked.
- R7: A sub-field with code 0x3C yields the 8 bytes that start 3 bytes past its header. The first of those bytes is the most significant byte of `wwn`. `wwn_off` gets the offset of that first byte and `found` is set.
- R8: When several 0x3C sub-fields occur, the last one walked sets the reported name and offset.
- R9: The scan also ends normally when the next tag offset reaches 128 or more, and any name found before that is still reported.
- R10: If any fetch address would reach 128 or more, the parse aborts without reading. It pulses `done` with `found` = 0, `wwn` = 0 and `wwn_off` = 0. `found` = 0 always comes with zero `wwn` and `wwn_off`.
- R11: Each read is a single-cycle `rd_en` with the byte in `rd_data` exactly RD_LAT cycles later. Reads are never issued on two consecutive cycles, and `done` lasts one cycle with no read in the following cycle.
- R12: A `start` pulse that arrives while a parse is running is ignored. That parse ends with exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a parse from offset 0 |
| rd_en | output | 1 | Byte read strobe |
| rd_addr | output | 7 | Byte address of the read |
| rd_data | input | 8 | Read data, valid RD_LAT cycles after rd_en |
| wwn | output | 64 | Extracted name, first byte most significant |
| wwn_off | output | 7 | Buffer offset of the first name byte, 0 when none |
| found | output | 1 | A name was extracted by the last parse |
| done | output | 1 | One-cycle pulse at the end of a parse |

## Verification
The hardest situation to reach from the ports is the abort on an out-of-range fetch. That abort must also wipe out a name that was already found earlier in the same parse. To reach it, the stimulus builds an image in which a valid name comes first, then an extended filler tag whose length lands the next header at offset 124, and then an identity tag whose sub-field length bytes would fall at 128. A twin image differs only in that the filler length carries the walk to exactly 128. In that image the scan must end normally and keep the name. The shortcut rule gets a decoy image, in which a real name sub-field would be reached if the walk entered the tag.

// File: rtl/wwn_pkg.sv
package wwn_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TAG,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_SUB_HDR,
        ST_SUB_LO,
        ST_SUB_HI,
        ST_NAME,
        ST_SUB_NEXT,
        ST_ADVANCE,
        ST_FINISH
    } walk_state_t;

    localparam logic [6:0] IDENT_TAG_CODE = 7'h0D;
    localparam logic [5:0] NAME_SUB_CODE  = 6'h3C;
    localparam logic [7:0] SHORTCUT_BYTE  = 8'h3B;
    localparam logic [3:0] END_TAG_NAME   = 4'hF;
    localparam int         SHORTCUT_LEN   = 6;
    localparam int         LONG_HDR_BYTES = 3;

endpackage

// File: rtl/wwn_tag_decode.sv
module wwn_tag_decode
    import wwn_pkg::*;
(
    input  logic [7:0] tag_byte,
    output logic       is_long,
    output logic       is_end,
    output logic [3:0] short_len,
    output logic [6:0] long_code
);

    always_comb begin
        is_long   = tag_byte[7];
        long_code = tag_byte[6:0];
        short_len = {1'b0, tag_byte[2:0]} + 4'd1;
        is_end    = !tag_byte[7] && (tag_byte[6:3] == END_TAG_NAME);
    end

endmodule

// File: rtl/wwn_fetch.sv
module wwn_fetch #(
    parameter int AW     = 7,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          dvld,
    output logic [7:0]    dbyte
);

    assign rd_en   = req;
    assign rd_addr = req_addr;
    assign dbyte   = rd_data;

    generate
        if (RD_LAT == 1) begin : g_lat_one
            logic vld_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) vld_q <= 1'b0;
                else        vld_q <= req;
            end
            assign dvld = vld_q;
        end else begin : g_lat_multi
            logic [RD_LAT-1:0] vld_pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) vld_pipe <= '0;
                else        vld_pipe <= {vld_pipe[RD_LAT-2:0], req};
            end
            assign dvld = vld_pipe[RD_LAT-1];
        end
    endgenerate

endmodule

// File: rtl/wwn_name_pack.sv
module wwn_name_pack #(
    parameter int NB = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            commit,
    input  logic [7:0]      byte_in,
    output logic [NB*8-1:0] name_q
);

    localparam int ACC_W = (NB - 1) * 8;

    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            name_q <= '0;
        end else begin
            if (shift_en)
                acc <= {acc[ACC_W-9:0], byte_in};
            if (clr)
                name_q <= '0;
            else if (commit)
                name_q <= {acc, byte_in};
        end
    end

endmodule

// File: rtl/wwn_tag_walker.sv
module wwn_tag_walker
    import wwn_pkg::*;
#(
    parameter int IMG_BYTES  = 128,
    parameter int RD_LAT     = 2,
    parameter int NAME_BYTES = 8,
    parameter int LEN_W      = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    output logic                      rd_en,
    output logic [$clog2(IMG_BYTES)-1:0] rd_addr,
    input  logic [7:0]                rd_data,
    output logic [NAME_BYTES*8-1:0]   wwn,
    output logic [$clog2(IMG_BYTES)-1:0] wwn_off,
    output logic                      found,
    output logic                      done
);

    localparam int AW = $clog2(IMG_BYTES);
    localparam int PW = LEN_W + 2;
    localparam int NW = $clog2(NAME_BYTES);
    localparam logic [PW-1:0] LIMIT    = PW'(IMG_BYTES);
    localparam logic [PW-1:0] HDR3     = PW'(LONG_HDR_BYTES);
    localparam logic [NW-1:0] NAME_END = NW'(NAME_BYTES - 1);

    walk_state_t state, nxt;

    logic [PW-1:0] pos, tlen, sub, slen;
    logic [7:0]    len_lo;
    logic [6:0]    lcode;
    logic [5:0]    scode;
    logic          first_sub;
    logic          pend;
    logic [NW-1:0] nidx;
    logic [AW-1:0] off_q;
    logic          found_q;

    logic [PW-1:0] want_addr;
    logic          rd_state, oob, req;
    logic          dvld;
    logic [7:0]    dbyte;
    logic [PW-1:0] desc_end, sub_step, pos_step;

    logic       d_long, d_end;
    logic [3:0] d_slen;
    logic [6:0] d_code;

    wwn_tag_decode u_dec (
        .tag_byte  (dbyte),
        .is_long   (d_long),
        .is_end    (d_end),
        .short_len (d_slen),
        .long_code (d_code)
    );

    wwn_fetch #(.AW(AW), .RD_LAT(RD_LAT)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_addr (want_addr[AW-1:0]),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .dvld     (dvld),
        .dbyte    (dbyte)
    );

    logic name_clr, name_shift, name_commit;

    wwn_name_pack #(.NB(NAME_BYTES)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (name_clr),
        .shift_en (name_shift),
        .commit   (name_commit),
        .byte_in  (dbyte),
        .name_q   (wwn)
    );

    assign desc_end = pos + tlen;
    assign sub_step = sub + slen + HDR3;
    assign pos_step = pos + tlen;

    // fetch address per state and range guard
    always_comb begin
        rd_state  = 1'b1;
        want_addr = '0;
        unique case (state)
            ST_TAG:     want_addr = pos;
            ST_LEN_LO:  want_addr = pos + PW'(1);
            ST_LEN_HI:  want_addr = pos + PW'(2);
            ST_SUB_HDR: want_addr = sub;
            ST_SUB_LO:  want_addr = sub + PW'(1);
            ST_SUB_HI:  want_addr = sub + PW'(2);
            ST_NAME:    want_addr = sub + HDR3 + PW'(nidx);
            default:    rd_state  = 1'b0;
        endcase
        oob = rd_state && (want_addr >= LIMIT);
        req = rd_state && !pend && !oob;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_TAG;
            ST_TAG:
                if (oob) nxt = ST_FINISH;
                else if (dvld) begin
                    if (d_long)     nxt = ST_LEN_LO;
                    else if (d_end) nxt = ST_FINISH;
                    else            nxt = ST_ADVANCE;
                end
            ST_LEN_LO:
                if (oob) nxt = ST_FINISH;
                else if (dvld) nxt = ST_LEN_HI;
            ST_LEN_HI:
                if (oob) nxt = ST_FINISH;
                else if (dvld)
                    nxt = (lcode == IDENT_TAG_CODE) ? ST_SUB_HDR : ST_ADVANCE;
            ST_SUB_HDR:
                if (oob) nxt = ST_FINISH;
                else if (dvld) begin
                    if (first_sub && dbyte == SHORTCUT_BYTE) nxt = ST_ADVANCE;
                    else if (sub >= desc_end)                nxt = ST_ADVANCE;
                    else                                     nxt = ST_SUB_LO;
                end
            ST_SUB_LO:
                if (oob) nxt = ST_FINISH;
                else if (dvld) nxt = ST_SUB_HI;
            ST_SUB_HI:
                if (oob) nxt = ST_FINISH;
                else if (dvld)
                    nxt = (scode == NAME_SUB_CODE) ? ST_NAME : ST_SUB_NEXT;
            ST_NAME:
                if (oob) nxt = ST_FINISH;
                else if (dvld && nidx == NAME_END) nxt = ST_SUB_NEXT;
            ST_SUB_NEXT: nxt = (sub_step < desc_end) ? ST_SUB_HDR : ST_ADVANCE;
            ST_ADVANCE:  nxt = (pos_step >= LIMIT) ? ST_FINISH : ST_TAG;
            ST_FINISH:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign name_clr    = (state == ST_IDLE && start) || oob;
    assign name_shift  = (state == ST_NAME) && dvld;
    assign name_commit = name_shift && (nidx == NAME_END);

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos       <= '0;
            tlen      <= '0;
            sub       <= '0;
            slen      <= '0;
            len_lo    <= '0;
            lcode     <= '0;
            scode     <= '0;
            first_sub <= 1'b0;
            pend      <= 1'b0;
            nidx      <= '0;
            off_q     <= '0;
            found_q   <= 1'b0;
        end else begin
            if (req)       pend <= 1'b1;
            else if (dvld) pend <= 1'b0;

            if (oob) begin
                found_q <= 1'b0;
                off_q   <= '0;
            end

            unique case (state)
                ST_IDLE:
                    if (start) begin
                        pos     <= '0;
                        found_q <= 1'b0;
                        off_q   <= '0;
                    end
                ST_TAG:
                    if (dvld) begin
                        if (d_long) lcode <= d_code;
                        else        tlen  <= PW'(d_slen);
                    end
                ST_LEN_LO:
                    if (dvld) len_lo <= dbyte;
                ST_LEN_HI:
                    if (dvld) begin
                        tlen      <= PW'({dbyte, len_lo}) + HDR3;
                        sub       <= pos + HDR3;
                        first_sub <= 1'b1;
                    end
                ST_SUB_HDR:
                    if (dvld) begin
                        first_sub <= 1'b0;
                        scode     <= dbyte[5:0];
                        if (first_sub && dbyte == SHORTCUT_BYTE)
                            tlen <= PW'(SHORTCUT_LEN);
                    end
                ST_SUB_LO:
                    if (dvld) len_lo <= dbyte;
                ST_SUB_HI:
                    if (dvld) begin
                        slen <= PW'({dbyte, len_lo});
                        nidx <= '0;
                    end
                ST_NAME:
                    if (dvld) begin
                        nidx <= nidx + NW'(1);
                        if (nidx == NAME_END) begin
                            found_q <= 1'b1;
                            off_q   <= AW'(sub + HDR3);
                        end
                    end
                ST_SUB_NEXT: sub <= sub_step;
                ST_ADVANCE:  pos <= pos_step;
                default: ;
            endcase
        end
    end

    assign found   = found_q;
    assign wwn_off = off_q;
    assign done    = (state == ST_FINISH);

endmodule

// File: rtl/wwn_walker_chk.sv
module wwn_walker_chk #(
    parameter int AW = 7,
    parameter int WW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic [AW-1:0] wwn_off,
    input logic [WW-1:0] wwn,
    input logic          found,
    input logic          done
);

    // R11: done is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: reads never issued back to back
    a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R11: no read in the cycle after done
    a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rd_en);

    // R7: a found name always sits past a sub-field header
    a_r7_offset_valid: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (wwn_off >= AW'(3)));

    // R10: no name means zeroed results
    a_r10_empty_when_absent: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (wwn_off == '0 && wwn == '0));

endmodule

bind wwn_tag_walker wwn_walker_chk #(
    .AW ($clog2(IMG_BYTES)),
    .WW (NAME_BYTES * 8)
) u_walker_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wwn_off (wwn_off),
    .wwn     (wwn),
    .found   (found),
    .done    (done)
);

// File: tb/test_wwn_tag_walker.sv
`timescale 1ns/1ps
module test_wwn_tag_walker;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_en;
    logic [6:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [63:0] wwn;
    logic [6:0]  wwn_off;
    logic        found;
    logic        done;

    always #2 clk = ~clk;

    wwn_tag_walker #(.IMG_BYTES(128), .RD_LAT(LAT), .NAME_BYTES(8), .LEN_W(16)) i_wwn_tag_walker (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wwn(wwn), .wwn_off(wwn_off), .found(found), .done(done)
    );

    // buffer model with fixed read latency; filler when idle
    logic [7:0] mem [0:127];
    logic [7:0] rpipe [LAT];
    always_ff @(posedge clk) begin
        rpipe[0] <= rd_en ? mem[rd_addr] : 8'h5A;
        for (int k = 1; k < LAT; k++) rpipe[k] <= rpipe[k-1];
    end
    assign rd_data = rpipe[LAT-1];

    int n_checks = 0;
    int n_fail = 0;
    int dones = 0;
    int cyc = 0;

    bit          q_found[$];
    int          q_off[$];
    logic [63:0] q_wwn[$];
    string       q_req[$];

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each done pulse
    bit prev_done = 1'b0;
    string prev_req = "";
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check(prev_req, "done single cycle (R11)", {63'd0, done}, 64'd0);
            prev_done = done;
            if (done) begin
                dones++;
                if (q_req.size() == 0) begin
                    check("R12", "unexpected done", 64'd1, 64'd0);
                end else begin
                    prev_req = q_req.pop_front();
                    check(prev_req, "found",   {63'd0, found}, {63'd0, q_found.pop_front()});
                    check(prev_req, "wwn_off", {57'd0, wwn_off}, 64'(q_off.pop_front()));
                    check(prev_req, "wwn",     wwn, q_wwn.pop_front());
                end
            end
        end
    end

    task automatic clear_mem();
        for (int a = 0; a < 128; a++) mem[a] = 8'h78;
    endtask

    task automatic put(int a, logic [7:0] b);
        mem[a] = b;
    endtask

    task automatic put_name(int a, logic [7:0] seed);
        for (int k = 0; k < 8; k++) mem[a+k] = seed + 8'(k * 17);
    endtask

    task automatic run_case(string req, bit f, int off, bit extra_start);
        logic [63:0] w = '0;
        int d0;
        if (f) for (int k = 0; k < 8; k++) w = {w[55:0], mem[off+k]};
        q_found.push_back(f);
        q_off.push_back(f ? off : 0);
        q_wwn.push_back(w);
        q_req.push_back(req);
        d0 = dones;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (extra_start) begin
            repeat (9) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (dones == d0) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        check("R1", "rd_en", {63'd0, rd_en}, 64'd0);
        check("R1", "done",  {63'd0, done}, 64'd0);
        check("R1", "found", {63'd0, found}, 64'd0);
        check("R1", "wwn",   wwn, 64'd0);
        check("R1", "wwn_off", {57'd0, wwn_off}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rd_en after release", {63'd0, rd_en}, 64'd0);

        // R2 R5 R7: compact tag, identity tag, name then a second sub-field
        clear_mem();
        put(0, 8'h12); put(3, 8'h8D); put(4, 8'h0E); put(5, 8'h00);
        put(6, 8'h3C); put(7, 8'h08); put(8, 8'h00); put_name(9, 8'h11);
        put(17, 8'h05); put(18, 8'h00); put(19, 8'h00); put(20, 8'h78);
        run_case("R2/R7", 1'b1, 9, 1'b0);

        // R4 R5: skipped extended tag with decoy, code from low 6 bits (0xFC)
        clear_mem();
        put(0, 8'h90); put(1, 8'h05); put(2, 8'h00);
        put(3, 8'h8D); put(4, 8'h08); put(5, 8'h00); put(6, 8'h3C); put(7, 8'h08);
        put(8, 8'h8D); put(9, 8'h0B); put(10, 8'h00);
        put(11, 8'hFC); put(12, 8'h08); put(13, 8'h00); put_name(14, 8'h23);
        put(22, 8'h7F);
        run_case("R4", 1'b1, 14, 1'b0);

        // R6: shortcut byte forces length 6, decoy name must not be found
        clear_mem();
        put(0, 8'h8D); put(1, 8'h14); put(2, 8'h00); put(3, 8'h3B);
        put(4, 8'h00); put(5, 8'h00); put(6, 8'h3C); put(7, 8'h08); put(8, 8'h00);
        put_name(9, 8'h31); put(11, 8'h78);
        run_case("R6", 1'b0, 0, 1'b0);

        // R8: two name sub-fields, the later wins
        clear_mem();
        put(0, 8'h8D); put(1, 8'h16); put(2, 8'h00);
        put(3, 8'h3C); put(4, 8'h08); put(5, 8'h00); put_name(6, 8'h41);
        put(14, 8'h3C); put(15, 8'h08); put(16, 8'h00); put_name(17, 8'h52);
        put(25, 8'h78);
        run_case("R8", 1'b1, 17, 1'b0);

        // R9: scan runs off the end at exactly 128, name kept
        clear_mem();
        put(0, 8'h8D); put(1, 8'h0B); put(2, 8'h00);
        put(3, 8'h3C); put(4, 8'h08); put(5, 8'h00); put_name(6, 8'h63);
        put(14, 8'h81); put(15, 8'h6F); put(16, 8'h00);
        run_case("R9", 1'b1, 6, 1'b0);

        // R10: earlier name, then a fetch at 128 aborts and clears
        clear_mem();
        put(0, 8'h8D); put(1, 8'h0B); put(2, 8'h00);
        put(3, 8'h3C); put(4, 8'h08); put(5, 8'h00); put_name(6, 8'h74);
        put(14, 8'h81); put(15, 8'h6B); put(16, 8'h00);
        put(124, 8'h8D); put(125, 8'h10); put(126, 8'h00); put(127, 8'h3C);
        run_case("R10", 1'b0, 0, 1'b0);

        // R3: end tag at offset 0 hides a valid structure behind it
        clear_mem();
        put(0, 8'h7D); put(1, 8'h8D); put(2, 8'h0B); put(3, 8'h00);
        put(4, 8'h3C); put(5, 8'h08); put(6, 8'h00); put_name(7, 8'h85);
        run_case("R3", 1'b0, 0, 1'b0);

        // R5: empty identity tag still fetches first body byte, then walks on
        clear_mem();
        put(0, 8'h8D); put(1, 8'h00); put(2, 8'h00); put(3, 8'h22);
        put(6, 8'h8D); put(7, 8'h0B); put(8, 8'h00);
        put(9, 8'h3C); put(10, 8'h08); put(11, 8'h00); put_name(12, 8'h96);
        put(20, 8'h78);
        run_case("R5", 1'b1, 12, 1'b0);

        // R12: second start while running must be ignored
        clear_mem();
        put(0, 8'h8D); put(1, 8'h16); put(2, 8'h00);
        put(3, 8'h3C); put(4, 8'h08); put(5, 8'h00); put_name(6, 8'hA7);
        put(14, 8'h3C); put(15, 8'h08); put(16, 8'h00); put_name(17, 8'hB8);
        put(25, 8'h78);
        run_case("R12", 1'b1, 17, 1'b1);
        check("R12", "scoreboard drained", 64'(q_req.size()), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule